// File: doc/BRIEF.md
# Serial Line Clock Activity Monitor

This block watches one transmit and one receive serial line clock for each of up to eight channel groups. For every clock it keeps a sticky activity flag that is set once the clock has shown two rising edges. The flags appear in a 32-bit status word that the host reads. Each line clock drives a toggle flop in its own domain. The toggle crosses into the host clock domain through a two-flop synchronizer and an edge detector. A small per-clock state machine in the host domain counts the arriving edge events.

The same host-domain edge events restart a timeout counter for each clock. A group's RAM counts as live while at least one of its two line clocks has produced an edge within the programmable timeout window. Host accesses to a group that is not live are intercepted. A read returns the marker word 32'hDEADACCE and a write never reaches the RAM.

Per-clock state machine (`act_state_e`):
- States: `ST_IDLE` (flag 0, no edge counted), `ST_ONE` (flag 0, one edge counted) and `ST_SET` (flag 1).
- Transitions: IDLE→ONE on an edge event; ONE→SET on an edge event; SET→IDLE on a status read with no edge in that cycle.
- Any state→IDLE on a bus reset, a soft chip reset or a soft reset of the clock's group. The reset takes priority over everything else.

Top module: `lca_monitor`

## Requirements
- R1: After bus reset (`rst_n` low) the status word reads 0 and every group is treated as not live.
- R2: Flag positions in the status word: transmit flag of group g (g<4) at bit 20+g, receive flag at bit 16+g; for g≥4 transmit at bit 28+(g-4), receive at bit 24+(g-4).
- R3: A flag becomes 1 only on the second line clock rising edge after the flag was last 0; one edge leaves it at 0.
- R4: A host status read (`stat_rd_i` high for one cycle) clears every flag on the next cycle. A read that finds a clock with one edge counted keeps that count, so one further edge sets the flag.
- R5: When an edge event and a status read reach a flag in the same host cycle, the flag ends at 1.
- R6: A soft group reset clears only that group's two flags and edge counts. A soft chip reset clears all of them.
- R7: Bits 15 down to 0 of the status word always read 0.
- R8: A line clock that never toggles leaves its flag at 0.
- R9: A RAM access to a group that is not live returns 32'hDEADACCE on `host_rdata_o`, and `ram_we_o` stays 0.
- R10: A RAM access to a live group passes `ram_rdata_i` to `host_rdata_o` and forwards the write enable.
- R11: A group stops being live once `timeout_lim_i` host cycles pass with no edge event on either of its clocks.
- R12: Groups whose line clock inputs carry the same shared clock each set their own flag from that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Bus reset, active low, asynchronous |
| soft_chip_rst_i | input | 1 | Soft reset of all groups, one host cycle |
| soft_grp_rst_i | input | NUM_GROUPS | Soft reset per group |
| tx_lclk_i | input | NUM_GROUPS | Transmit line clock per group |
| rx_lclk_i | input | NUM_GROUPS | Receive line clock per group |
| stat_rd_i | input | 1 | Host read strobe for the status word |
| stat_word_o | output | 32 | Activity status word |
| timeout_lim_i | input | TO_W | Host cycles without an edge before a clock counts as absent |
| ram_req_i | input | 1 | Host RAM access request |
| ram_we_i | input | 1 | Host RAM access is a write |
| ram_grp_i | input | GRP_W | Target group of the RAM access |
| ram_rdata_i | input | 32 | Read data from the group RAM |
| ram_en_o | output | 1 | RAM enable, only for a live group |
| ram_we_o | output | 1 | RAM write enable, only for a live group |
| host_rdata_o | output | 32 | Read data to the host, or the marker word |

## Verification
The bench builds the block with all eight groups and a 16-bit timeout limit. This covers every bit position in both halves of the status word, including the top group 7 and the group 4/3 boundary. The limit is driven at run time: a large value keeps groups live through the long stimulus walk, and a value of 20 makes a lapse visible within a few dozen cycles. Line clock edges are placed on exact host cycles. This lets a status read land in the same cycle as a synchronized edge event, and lets one clock drive two groups at once.

// File: rtl/lca_pkg.sv
package lca_pkg;

    localparam int unsigned STAT_W    = 32;
    localparam logic [31:0] DEAD_WORD = 32'hDEADACCE;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ONE  = 2'd1,
        ST_SET  = 2'd2
    } act_state_e;

    // Status word position of a flag: groups 0..3 in bits 23:16, 4..7 in 31:24
    function automatic int unsigned flag_pos(input bit is_tx, input int unsigned grp);
        int unsigned base;
        base = (grp >= 4) ? 24 : 16;
        return base + (is_tx ? 4 : 0) + (grp % 4);
    endfunction

endpackage

// File: rtl/lca_line_toggle.sv
module lca_line_toggle (
    input  logic lclk_i,
    input  logic rst_n,
    output logic tgl_o
);

    // Flips once per rising line clock edge, inside the line clock domain
    always_ff @(posedge lclk_i or negedge rst_n) begin
        if (!rst_n) begin
            tgl_o <= 1'b0;
        end else begin
            tgl_o <= ~tgl_o;
        end
    end

endmodule

// File: rtl/lca_sync_edge.sv
module lca_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic pulse_o
);

    logic s1_q;
    logic s2_q;
    logic s3_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= async_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    // One host-cycle pulse per change of the synchronized toggle
    assign pulse_o = s2_q ^ s3_q;

    p_pulse_follows_change_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> (s2_q != $past(s2_q)));

endmodule

// File: rtl/lca_chan.sv
module lca_chan
    import lca_pkg::*;
#(
    parameter int unsigned TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            rd_i,
    input  logic            lclk_i,
    input  logic [TO_W-1:0] lim_i,
    output logic            act_o,
    output logic            present_o
);

    logic       tgl;
    logic       evt;
    act_state_e st_q;
    act_state_e st_d;

    logic [TO_W-1:0] idle_cnt_q;
    logic            seen_q;

    lca_line_toggle u_tgl (
        .lclk_i (lclk_i),
        .rst_n  (rst_n),
        .tgl_o  (tgl)
    );

    lca_sync_edge u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (tgl),
        .pulse_o (evt)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state: reset first, then edge events, then read clear
    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: if (evt) st_d = ST_ONE;
                ST_ONE:  if (evt) st_d = ST_SET;
                ST_SET:  if (rd_i && !evt) st_d = ST_IDLE;
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        act_o     = (st_q == ST_SET);
        present_o = seen_q && (idle_cnt_q < lim_i);
    end

    // Host-domain timeout for clock presence
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_cnt_q <= '0;
            seen_q     <= 1'b0;
        end else if (clr_i) begin
            idle_cnt_q <= '0;
            seen_q     <= 1'b0;
        end else if (evt) begin
            idle_cnt_q <= '0;
            seen_q     <= 1'b1;
        end else if (idle_cnt_q < lim_i) begin
            idle_cnt_q <= idle_cnt_q + 1'b1;
        end
    end

    p_set_after_two_edges_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_o) |-> ($past(evt) && $past(st_q == ST_ONE)));

    p_read_clears_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !evt && !clr_i && act_o) |=> !act_o);

    p_set_wins_r5 : assert property (@(posedge clk) disable iff (!rst_n)
        (act_o && rd_i && evt && !clr_i) |=> act_o);

    p_soft_clear_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q == ST_IDLE && !present_o));

    p_absence_holds_r11 : assert property (@(posedge clk) disable iff (!rst_n)
        (!present_o && !evt) |=> (!present_o || (lim_i != $past(lim_i))));

endmodule

// File: rtl/lca_ram_gate.sv
module lca_ram_gate
    import lca_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 8,
    parameter int unsigned GRP_W      = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_GROUPS-1:0] live_i,
    input  logic                  req_i,
    input  logic                  we_i,
    input  logic [GRP_W-1:0]      grp_i,
    input  logic [31:0]           ram_rdata_i,
    output logic                  ram_en_o,
    output logic                  ram_we_o,
    output logic [31:0]           host_rdata_o
);

    localparam int unsigned PAD_N = 1 << GRP_W;

    logic [PAD_N-1:0] live_pad;
    logic             tgt_live;

    always_comb begin
        live_pad                 = '0;
        live_pad[NUM_GROUPS-1:0] = live_i;
        tgt_live                 = live_pad[grp_i];
        ram_en_o                 = req_i && tgt_live;
        ram_we_o                 = req_i && we_i && tgt_live;
        host_rdata_o             = tgt_live ? ram_rdata_i : DEAD_WORD;
    end

    p_dead_access_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !live_i[grp_i % NUM_GROUPS] && (grp_i < NUM_GROUPS)) |->
            (host_rdata_o == DEAD_WORD && !ram_we_o && !ram_en_o));

    p_live_write_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && we_i && ram_en_o) |-> ram_we_o);

endmodule

// File: rtl/lca_monitor.sv
module lca_monitor
    import lca_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 8,
    parameter int unsigned TO_W       = 16,
    parameter int unsigned GRP_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  soft_chip_rst_i,
    input  logic [NUM_GROUPS-1:0] soft_grp_rst_i,
    input  logic [NUM_GROUPS-1:0] tx_lclk_i,
    input  logic [NUM_GROUPS-1:0] rx_lclk_i,
    input  logic                  stat_rd_i,
    output logic [31:0]           stat_word_o,
    input  logic [TO_W-1:0]       timeout_lim_i,
    input  logic                  ram_req_i,
    input  logic                  ram_we_i,
    input  logic [GRP_W-1:0]      ram_grp_i,
    input  logic [31:0]           ram_rdata_i,
    output logic                  ram_en_o,
    output logic                  ram_we_o,
    output logic [31:0]           host_rdata_o
);

    logic [NUM_GROUPS-1:0] tx_act;
    logic [NUM_GROUPS-1:0] rx_act;
    logic [NUM_GROUPS-1:0] tx_pres;
    logic [NUM_GROUPS-1:0] rx_pres;
    logic [NUM_GROUPS-1:0] grp_clr;
    logic [NUM_GROUPS-1:0] grp_live;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign grp_clr[g]  = soft_chip_rst_i || soft_grp_rst_i[g];
        assign grp_live[g] = tx_pres[g] || rx_pres[g];

        lca_chan #(.TO_W(TO_W)) u_tx (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_i     (grp_clr[g]),
            .rd_i      (stat_rd_i),
            .lclk_i    (tx_lclk_i[g]),
            .lim_i     (timeout_lim_i),
            .act_o     (tx_act[g]),
            .present_o (tx_pres[g])
        );

        lca_chan #(.TO_W(TO_W)) u_rx (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_i     (grp_clr[g]),
            .rd_i      (stat_rd_i),
            .lclk_i    (rx_lclk_i[g]),
            .lim_i     (timeout_lim_i),
            .act_o     (rx_act[g]),
            .present_o (rx_pres[g])
        );
    end

    always_comb begin
        stat_word_o = '0;
        for (int unsigned g = 0; g < NUM_GROUPS; g++) begin
            stat_word_o[flag_pos(1'b1, g)] = tx_act[g];
            stat_word_o[flag_pos(1'b0, g)] = rx_act[g];
        end
    end

    lca_ram_gate #(
        .NUM_GROUPS (NUM_GROUPS),
        .GRP_W      (GRP_W)
    ) u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .live_i       (grp_live),
        .req_i        (ram_req_i),
        .we_i         (ram_we_i),
        .grp_i        (ram_grp_i),
        .ram_rdata_i  (ram_rdata_i),
        .ram_en_o     (ram_en_o),
        .ram_we_o     (ram_we_o),
        .host_rdata_o (host_rdata_o)
    );

    p_low_half_zero_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd_i |-> (stat_word_o[15:0] == 16'h0000));

    p_chip_clear_r6 : assert property (@(posedge clk) disable iff (!rst_n)
        soft_chip_rst_i |=> (stat_word_o == 32'h0));

endmodule

// File: tb/lca_monitor_tb.sv
module lca_monitor_tb;

    localparam int NG   = 8;
    localparam int TOW  = 16;
    localparam int NVEC = 12;
    localparam logic [31:0] DEAD = 32'hDEADACCE;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            soft_chip_rst = 1'b0;
    logic [NG-1:0]   soft_grp_rst = '0;
    logic [NG-1:0]   tx_lclk = '0;
    logic [NG-1:0]   rx_lclk = '0;
    logic            stat_rd = 1'b0;
    logic [31:0]     stat_word;
    logic [TOW-1:0]  lim = 16'd200;
    logic            ram_req = 1'b0;
    logic            ram_we = 1'b0;
    logic [2:0]      ram_grp = '0;
    logic [31:0]     ram_rdata = 32'h1234_5678;
    logic            ram_en;
    logic            ram_we_q;
    logic [31:0]     host_rdata;

    int errors = 0;
    int checks = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    lca_monitor #(.NUM_GROUPS(NG), .TO_W(TOW)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .soft_chip_rst_i (soft_chip_rst),
        .soft_grp_rst_i  (soft_grp_rst),
        .tx_lclk_i       (tx_lclk),
        .rx_lclk_i       (rx_lclk),
        .stat_rd_i       (stat_rd),
        .stat_word_o     (stat_word),
        .timeout_lim_i   (lim),
        .ram_req_i       (ram_req),
        .ram_we_i        (ram_we),
        .ram_grp_i       (ram_grp),
        .ram_rdata_i     (ram_rdata),
        .ram_en_o        (ram_en),
        .ram_we_o        (ram_we_q),
        .host_rdata_o    (host_rdata)
    );

    // Independent bit map from R2
    function automatic logic [31:0] fbit(input bit is_tx, input int g);
        int p;
        p = (g < 4) ? (16 + g) : (24 + g - 4);
        if (is_tx) p = p + 4;
        return 32'h1 << p;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One rising and falling edge on the selected line clocks
    task automatic pulse(input logic [NG-1:0] txm, input logic [NG-1:0] rxm);
        @(negedge clk);
        tx_lclk = tx_lclk | txm;
        rx_lclk = rx_lclk | rxm;
        repeat (3) @(negedge clk);
        tx_lclk = tx_lclk & ~txm;
        rx_lclk = rx_lclk & ~rxm;
        repeat (3) @(negedge clk);
    endtask

    task automatic host_read(input string req, input logic [31:0] exp);
        @(negedge clk);
        chk(req, stat_word, exp);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic ram_access(input logic [2:0] g, input logic we);
        @(negedge clk);
        ram_grp = g;
        ram_we  = we;
        ram_req = 1'b1;
        #1;
    endtask

    // Vector table: op 0 = tx edge, 1 = rx edge, 2 = host read; expected word after op / before read
    localparam logic [1:0]  VOP [NVEC] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd0, 2'd0,
                                            2'd2, 2'd2, 2'd1, 2'd2, 2'd1, 2'd2};
    localparam int          VGRP[NVEC] = '{0, 0, 5, 5, 7, 7, 0, 0, 2, 0, 2, 0};
    localparam logic [31:0] VEXP[NVEC] = '{32'h0000_0000, 32'h0010_0000, 32'h0010_0000,
                                            32'h0210_0000, 32'h0210_0000, 32'h8210_0000,
                                            32'h8210_0000, 32'h0000_0000, 32'h0000_0000,
                                            32'h0000_0000, 32'h0004_0000, 32'h0004_0000};

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset word", stat_word, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 word after reset", stat_word, 32'h0);

        // R2 R3 R4 R8: table walk
        for (int i = 0; i < NVEC; i++) begin
            if (VOP[i] == 2'd0) begin
                pulse(NG'(1) << VGRP[i], '0);
                chk($sformatf("R3 R2 vec%0d", i), stat_word, VEXP[i]);
            end else if (VOP[i] == 2'd1) begin
                pulse('0, NG'(1) << VGRP[i]);
                chk($sformatf("R4 R2 vec%0d", i), stat_word, VEXP[i]);
            end else begin
                host_read($sformatf("R4 read vec%0d", i), VEXP[i]);
            end
        end
        host_read("R4 cleared", 32'h0);
        chk("R7 low half", {16'h0, stat_word[15:0]}, 32'h0);
        chk("R8 silent group 6", stat_word & (fbit(1, 6) | fbit(0, 6)), 32'h0);

        // R9: group 6 never clocked
        ram_access(3'd6, 1'b1);
        chk("R9 dead read", host_rdata, DEAD);
        chk("R9 write dropped", {31'h0, ram_we_q}, 32'h0);
        ram_req = 1'b0;

        // R10: group 1 freshly clocked
        pulse(8'h02, '0);
        ram_access(3'd1, 1'b1);
        chk("R10 read passes", host_rdata, 32'h1234_5678);
        chk("R10 write forwarded", {31'h0, ram_we_q}, 32'h1);
        ram_req = 1'b0;

        // R11: short limit lapses
        lim = 16'd20;
        pulse('0, 8'h08);
        ram_access(3'd3, 1'b0);
        chk("R11 live before lapse", host_rdata, 32'h1234_5678);
        ram_req = 1'b0;
        repeat (30) @(negedge clk);
        ram_access(3'd3, 1'b0);
        chk("R11 dead after lapse", host_rdata, DEAD);
        ram_req = 1'b0;
        lim = 16'd200;

        // R5: set wins over read clear in the same host cycle
        host_read("R5 pre-clear", stat_word);
        pulse(8'h10, '0);
        pulse(8'h10, '0);
        @(negedge clk);
        tx_lclk[4] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        tx_lclk[4] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R5 set kept over read", stat_word, fbit(1, 4));

        // R6: soft group reset and soft chip reset
        pulse('0, 8'h09);
        pulse('0, 8'h09);
        chk("R6 before group reset", stat_word, fbit(1, 4) | fbit(0, 0) | fbit(0, 3));
        @(negedge clk);
        soft_grp_rst[3] = 1'b1;
        @(negedge clk);
        soft_grp_rst[3] = 1'b0;
        chk("R6 group 3 only", stat_word, fbit(1, 4) | fbit(0, 0));
        @(negedge clk);
        soft_chip_rst = 1'b1;
        @(negedge clk);
        soft_chip_rst = 1'b0;
        chk("R6 chip reset", stat_word, 32'h0);

        // R12: one clock shared by groups 5 and 6
        pulse(8'h60, '0);
        pulse(8'h60, '0);
        chk("R12 shared clock", stat_word, fbit(1, 5) | fbit(1, 6));

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule